// File: doc/BRIEF.md
# Successive-Approximation Converter Control and Result Registers

This block is the digital side of a 10-bit successive-approximation converter. It divides the system clock by a selectable factor to make the converter clock. It runs single conversions or free-running back-to-back conversions, and it raises a completion flag at the end of each one. The analog front end is not part of the block. At the last converter clock of each conversion, the block takes the result from the `sampleData` port.

Software reaches the block through a small register port with four byte addresses:

| Address | Register | Access |
|---|---|---|
| 0 | control/status | read and write |
| 1 | pending channel and alignment setting | read and write |
| 2 | result low byte | read only |
| 3 | result high byte | read only |

A read strobe on the low byte freezes the visible result pair, so that the two bytes always belong to the same conversion. A read strobe on the high byte releases the pair. Channel and alignment writes go to a pending copy, which becomes active only when a conversion starts.

Top module: `adc_ctl`

## Requirements
- R1: Control bits 2..0 select the converter clock divider: codes 0 and 1 divide by 2, and codes 2 to 7 divide by 2^code (4, 8, 16, 32, 64, 128). In free-running mode, successive completions are exactly 13 × divider system clocks apart.
- R2: The first conversion after the converter is enabled (control bit 7 goes from 0 to 1) lasts 25 converter clocks. When enable and start are written together from the disabled state, the completion flag sets exactly 25 × divider cycles after that write.
- R3: The result is the value on `sampleData` at the last converter clock. With the alignment bit (address 1, bit 5) clear, the high byte reads {6'b0, result[9:8]} and the low byte reads result[7:0]. Both 0x000 and 0x3FF are carried unchanged.
- R4: With the alignment bit set, the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}.
- R5: After reset, all four addresses read 0x00 and `irq` is low.
- R6: A read of the low byte freezes both result bytes. Results that complete while the pair is frozen are held, with the newest one kept. A read of the high byte releases the freeze, and the held result then becomes visible.
- R7: When software reads only the high byte, no freeze occurs, and every new conversion appears in the high byte.
- R8: Channel (address 1, bits 3..0) and alignment writes take effect only at the start of a conversion. `convChannel` and the alignment of the running conversion do not change while a conversion is in progress.
- R9: In free-running mode, the next conversion starts in the same cycle that the flag sets. A channel written after that cycle is therefore applied only to the conversion after the next one.
- R10: The completion flag (control bit 4, also driven on `irq`) sets at each completion. It clears on a control write with bit 4 = 1, or on an `irqAck` pulse. A control write with bit 4 = 0 leaves it unchanged.
- R11: Control bit 6 reads 1 while a conversion is in progress and 0 after a single conversion completes. A start written while the converter is disabled does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdEn | input | 1 | Register read strobe; produces the freeze and release side effects |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Read data for `rdAddr` (combinational) |
| irqAck | input | 1 | Interrupt acknowledge; clears the flag |
| irq | output | 1 | Completion flag |
| sampleData | input | 10 | Conversion value from the analog side |
| convChannel | output | CH_W | Channel of the conversion now running |

## Verification
The assertions check the following on every cycle:
- Converter clock ticks are never adjacent.
- The flag rises only on a completion strobe.
- A completion happens only while a conversion is active.
- A channel write during a conversion leaves `convChannel` unchanged.
- A low-byte read always leaves the pair frozen.
- The visible result stays stable while frozen.

The bench scenarios show everything that needs a count over many cycles or a data comparison:
- exact conversion lengths for all eight divider codes;
- byte placement for both alignments over a sweep of values;
- which held result appears after the release;
- the one-conversion delay of a channel written after a free-running completion.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  // register addresses
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_MUX = 2'd1;
  localparam logic [1:0] ADDR_LO  = 2'd2;
  localparam logic [1:0] ADDR_HI  = 2'd3;

  // control register bit positions
  localparam int BIT_EN   = 7;
  localparam int BIT_GO   = 6;
  localparam int BIT_FREE = 5;
  localparam int BIT_FLAG = 4;
  // mux register alignment bit
  localparam int MUX_LEFT = 5;

  localparam int SEL_W = 3;

  typedef struct packed {
    logic             en;
    logic             go;
    logic             free;
    logic             clr;
    logic [SEL_W-1:0] psel;
  } ctlWr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic finish;
    logic readLo;
    logic readHi;
  } adcStb_t;
endpackage

// File: rtl/adc_ctl_fsm.sv
module adc_ctl_fsm
  import adc_ctl_pkg::*;
#(
  parameter int CONV_TICKS  = 13,
  parameter int FIRST_TICKS = 25
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrCtl,
  input  ctlWr_t     ctlIn,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  input  logic       irqAck,
  output adcStb_t    stb,
  output logic [7:0] ctlStatus,
  output logic       irq,
  output logic       busy,
  output logic       tick
);
  localparam int PS_W = (1 << SEL_W) - 1;
  localparam int TC_W = $clog2(FIRST_TICKS + 1);

  logic             en, freeRun, busyR, flag, isFirst;
  logic [SEL_W-1:0] psel;
  logic [PS_W-1:0]  psCnt, psMask;
  logic [TC_W-1:0]  tickCnt, lastTick;
  logic             finish, startReq;

  always_comb begin
    if (psel < SEL_W'(2)) psMask = PS_W'(1);
    else                  psMask = PS_W'((1 << psel) - 1);
  end

  assign tick     = en && ((psCnt & psMask) == psMask);
  assign lastTick = isFirst ? TC_W'(FIRST_TICKS - 1) : TC_W'(CONV_TICKS - 1);
  assign finish   = busyR && tick && (tickCnt == lastTick);
  assign startReq = wrCtl && ctlIn.en && ctlIn.go && !busyR;

  assign stb.start  = startReq || (finish && freeRun);
  assign stb.finish = finish;
  assign stb.readLo = rdEn && (rdAddr == ADDR_LO);
  assign stb.readHi = rdEn && (rdAddr == ADDR_HI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en      <= 1'b0;
      freeRun <= 1'b0;
      psel    <= '0;
      busyR   <= 1'b0;
      flag    <= 1'b0;
      isFirst <= 1'b1;
      psCnt   <= '0;
      tickCnt <= '0;
    end else begin
      if (wrCtl) begin
        en      <= ctlIn.en;
        freeRun <= ctlIn.free;
        psel    <= ctlIn.psel;
      end
      psCnt <= en ? psCnt + 1'b1 : '0;

      if (wrCtl && !ctlIn.en)       busyR <= 1'b0;
      else if (startReq)            busyR <= 1'b1;
      else if (finish && !freeRun)  busyR <= 1'b0;

      if (stb.start)          tickCnt <= '0;
      else if (busyR && tick) tickCnt <= tickCnt + 1'b1;

      if (!en)         isFirst <= 1'b1;
      else if (finish) isFirst <= 1'b0;

      if (finish)                           flag <= 1'b1;
      else if (irqAck || (wrCtl && ctlIn.clr)) flag <= 1'b0;
    end
  end

  assign ctlStatus = {en, busyR, freeRun, flag, 1'b0, psel};
  assign irq       = flag;
  assign busy      = busyR;
endmodule

// File: rtl/adc_ctl_dp.sv
module adc_ctl_dp
  import adc_ctl_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  adcStb_t          stb,
  input  logic             wrMux,
  input  logic [CH_W-1:0]  wrChan,
  input  logic             wrLeft,
  input  logic [RES_W-1:0] sampleData,
  input  logic [1:0]       rdAddr,
  input  logic [7:0]       ctlStatus,
  output logic [7:0]       rdData,
  output logic [CH_W-1:0]  convChannel,
  output logic [RES_W-1:0] visRes,
  output logic             locked
);
  localparam int LO_W = RES_W - 8;

  logic [CH_W-1:0]  pendChan, actChan;
  logic             pendLeft, actLeft;
  logic [RES_W-1:0] visVal, holdVal;
  logic             visLeft, holdLeft, holdV, lockR;
  logic             toHold;
  logic [7:0]       hiByte, loByte, muxRead;

  assign toHold = stb.finish && (lockR || stb.readLo) && !stb.readHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendChan <= '0; pendLeft <= 1'b0;
      actChan  <= '0; actLeft  <= 1'b0;
      visVal   <= '0; visLeft  <= 1'b0;
      holdVal  <= '0; holdLeft <= 1'b0;
      holdV    <= 1'b0;
      lockR    <= 1'b0;
    end else begin
      if (wrMux) begin
        pendChan <= wrChan;
        pendLeft <= wrLeft;
      end
      if (stb.start) begin
        actChan <= pendChan;
        actLeft <= pendLeft;
      end

      if (toHold) begin
        holdVal  <= sampleData;
        holdLeft <= actLeft;
        holdV    <= 1'b1;
      end else if (stb.finish) begin
        visVal  <= sampleData;
        visLeft <= actLeft;
        if (stb.readHi) holdV <= 1'b0;
      end else if (stb.readHi && holdV) begin
        visVal  <= holdVal;
        visLeft <= holdLeft;
        holdV   <= 1'b0;
      end

      if (stb.readHi)      lockR <= 1'b0;
      else if (stb.readLo) lockR <= 1'b1;
    end
  end

  always_comb begin
    if (visLeft) begin
      hiByte = visVal[RES_W-1 -: 8];
      loByte = 8'({visVal[LO_W-1:0], {(8 - LO_W){1'b0}}});
    end else begin
      hiByte = 8'(visVal >> 8);
      loByte = visVal[7:0];
    end
    muxRead = '0;
    muxRead[CH_W-1:0] = pendChan;
    muxRead[MUX_LEFT] = pendLeft;
    case (rdAddr)
      ADDR_CTL: rdData = ctlStatus;
      ADDR_MUX: rdData = muxRead;
      ADDR_LO:  rdData = loByte;
      default:  rdData = hiByte;
    endcase
  end

  assign convChannel = actChan;
  assign visRes      = visVal;
  assign locked      = lockR;
endmodule

// File: rtl/adc_ctl.sv
module adc_ctl
  import adc_ctl_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int RES_W       = 10,
  parameter int CONV_TICKS  = 13,
  parameter int FIRST_TICKS = 25
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic             rdEn,
  input  logic [1:0]       rdAddr,
  output logic [7:0]       rdData,
  input  logic             irqAck,
  output logic             irq,
  input  logic [RES_W-1:0] sampleData,
  output logic [CH_W-1:0]  convChannel
);
  adcStb_t          stb;
  ctlWr_t           ctlIn;
  logic [7:0]       ctlStatus;
  logic             wrCtl, wrMux, busyW, tickW, lockedW;
  logic [RES_W-1:0] visResW;

  assign wrCtl = wrEn && (wrAddr == ADDR_CTL);
  assign wrMux = wrEn && (wrAddr == ADDR_MUX);
  assign ctlIn = '{en: wrData[BIT_EN], go: wrData[BIT_GO], free: wrData[BIT_FREE],
                   clr: wrData[BIT_FLAG], psel: wrData[SEL_W-1:0]};

  adc_ctl_fsm #(.CONV_TICKS(CONV_TICKS), .FIRST_TICKS(FIRST_TICKS)) u_fsm (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .ctlIn(ctlIn), .rdEn(rdEn),
    .rdAddr(rdAddr), .irqAck(irqAck), .stb(stb), .ctlStatus(ctlStatus),
    .irq(irq), .busy(busyW), .tick(tickW)
  );

  adc_ctl_dp #(.CH_W(CH_W), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrMux(wrMux),
    .wrChan(wrData[CH_W-1:0]), .wrLeft(wrData[MUX_LEFT]),
    .sampleData(sampleData), .rdAddr(rdAddr), .ctlStatus(ctlStatus),
    .rdData(rdData), .convChannel(convChannel), .visRes(visResW),
    .locked(lockedW)
  );
endmodule

// File: rtl/adc_ctl_chk.sv
module adc_ctl_chk
  import adc_ctl_pkg::*;
#(
  parameter int CH_W  = 4,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input adcStb_t          stb,
  input logic             irq,
  input logic             busy,
  input logic             tick,
  input logic             wrMux,
  input logic [CH_W-1:0]  convChannel,
  input logic [RES_W-1:0] visRes,
  input logic             locked
);
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(stb.finish));

  p_finish_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |-> busy);

  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrMux && busy && !stb.start) |=> $stable(convChannel));

  p_lock_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.readLo |=> locked);

  p_lock_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !stb.readHi) |=> $stable(visRes));
endmodule

bind adc_ctl adc_ctl_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .irq(irq), .busy(busyW), .tick(tickW),
  .wrMux(wrMux), .convChannel(convChannel), .visRes(visResW), .locked(lockedW)
);

// File: tb/adc_ctl_tb.sv
module adc_ctl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, irqAck = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq;
  logic [9:0] sampleData = '0;
  logic [3:0] convChannel;

  int cyc = 0;
  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_ctl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .irqAck(irqAck),
    .irq(irq), .sampleData(sampleData), .convChannel(convChannel)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIrq(input bit ack, output int t);
    int n = 0;
    while (!irq && n < 40000) begin
      @(negedge clk);
      n++;
    end
    t = cyc;
    if (!irq) chk(1'b0, "R10 completion timeout", 0, 1);
    if (ack) begin
      irqAck = 1'b1;
      @(negedge clk);
      irqAck = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    int t0, t1, t2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R5: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 8'h00, "R5 reset read", d, 0);
    end
    chk(irq == 1'b0, "R5 irq after reset", irq, 0);

    // R1 / R2: divider sweep in free-running mode
    for (int p = 0; p < 8; p++) begin
      int dv;
      dv = (p < 2) ? 2 : (1 << p);
      wr(2'd1, 8'h03);
      wr(2'd0, 8'hE0 | 8'(p));
      t0 = cyc;
      waitIrq(1'b1, t1);
      chk(t1 - t0 == 25 * dv, "R2 first conversion length", t1 - t0, 25 * dv);
      waitIrq(1'b1, t2);
      chk(t2 - t1 == 13 * dv, "R1 free-run period", t2 - t1, 13 * dv);
      wr(2'd0, 8'h00);
    end

    // R3 / R4 / R11: format sweep in single mode
    wr(2'd0, 8'h80);
    for (int i = 0; i < 48; i++) begin
      logic [9:0] v;
      bit left;
      v = 10'((i * 97 + i * i * 13) & 10'h3FF);
      if (i == 0) v = 10'h000;
      if (i == 1) v = 10'h3FF;
      if (i == 2) v = 10'h000;
      if (i == 3) v = 10'h3FF;
      left = i[0];
      sampleData = v;
      wr(2'd1, left ? 8'h20 : 8'h00);
      wr(2'd0, 8'hC0);
      rd(2'd0, d);
      chk(d[6] == 1'b1, "R11 busy during conversion", d, 8'hC0);
      waitIrq(1'b1, t1);
      rd(2'd0, d);
      chk(d == 8'h80, "R11 busy clear after single", d, 8'h80);
      rd(2'd2, lo);
      rd(2'd3, hi);
      if (left) begin
        chk(hi == v[9:2], "R4 left high byte", hi, v[9:2]);
        chk(lo == {v[1:0], 6'b0}, "R4 left low byte", lo, {v[1:0], 6'b0});
      end else begin
        chk(hi == {6'b0, v[9:8]}, "R3 right high byte", hi, {6'b0, v[9:8]});
        chk(lo == v[7:0], "R3 right low byte", lo, v[7:0]);
      end
    end

    // R6: low-byte read freezes the pair, newest result held
    wr(2'd1, 8'h00);
    sampleData = 10'h2A5;
    wr(2'd0, 8'hE0);
    waitIrq(1'b1, t1);
    sampleData = 10'h15A;
    rd(2'd2, lo);
    chk(lo == 8'hA5, "R6 first low read", lo, 8'hA5);
    waitIrq(1'b1, t1);
    sampleData = 10'h3C3;
    waitIrq(1'b1, t1);
    rd(2'd2, lo);
    chk(lo == 8'hA5, "R6 low frozen", lo, 8'hA5);
    rd(2'd3, hi);
    chk(hi == 8'h02, "R6 high of frozen pair", hi, 8'h02);
    rd(2'd2, lo);
    chk(lo == 8'hC3, "R6 held low after release", lo, 8'hC3);
    rd(2'd3, hi);
    chk(hi == 8'h03, "R6 held high after release", hi, 8'h03);
    wr(2'd0, 8'h00);

    // R7: left aligned, high byte only
    wr(2'd1, 8'h20);
    sampleData = 10'h111;
    wr(2'd0, 8'hE0);
    for (int k = 0; k < 4; k++) begin
      logic [9:0] v;
      v = 10'(10'h0C4 + k * 10'h0B7);
      sampleData = v;
      waitIrq(1'b1, t1);
      waitIrq(1'b1, t1);
      rd(2'd3, hi);
      chk(hi == v[9:2], "R7 high-only read", hi, v[9:2]);
    end
    wr(2'd0, 8'h00);

    // R8 / R9: channel shadowing
    wr(2'd1, 8'h03);
    wr(2'd0, 8'hE0);
    repeat (10) @(negedge clk);
    wr(2'd1, 8'h09);
    chk(convChannel == 4'd3, "R8 channel held mid-conversion", convChannel, 3);
    waitIrq(1'b1, t1);
    chk(convChannel == 4'd9, "R8 channel applied at start", convChannel, 9);
    wr(2'd1, 8'h05);
    chk(convChannel == 4'd9, "R9 late write not applied", convChannel, 9);
    waitIrq(1'b1, t1);
    chk(convChannel == 4'd5, "R9 applied one conversion later", convChannel, 5);
    wr(2'd0, 8'h00);

    // R8: alignment change mid-conversion
    wr(2'd1, 8'h00);
    sampleData = 10'h2B7;
    wr(2'd0, 8'hC0);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h20);
    waitIrq(1'b1, t1);
    rd(2'd2, lo);
    rd(2'd3, hi);
    chk(hi == 8'h02 && lo == 8'hB7, "R8 alignment held", {hi, lo}, 16'h02B7);
    wr(2'd0, 8'hC0);
    waitIrq(1'b1, t1);
    rd(2'd2, lo);
    rd(2'd3, hi);
    chk(hi == 8'hAD && lo == 8'hC0, "R8 alignment applied next", {hi, lo}, 16'hADC0);

    // R10: flag clearing
    wr(2'd0, 8'hC0);
    waitIrq(1'b0, t1);
    wr(2'd0, 8'h80);
    rd(2'd0, d);
    chk(d[4] == 1'b1 && irq == 1'b1, "R10 zero write keeps flag", d, 8'h90);
    wr(2'd0, 8'h90);
    @(negedge clk);
    chk(irq == 1'b0, "R10 write-one clears flag", irq, 0);
    wr(2'd0, 8'hC0);
    waitIrq(1'b1, t1);
    chk(irq == 1'b0, "R10 acknowledge clears flag", irq, 0);

    // R11: start ignored while disabled
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h40);
    rd(2'd0, d);
    chk(d == 8'h00, "R11 start while disabled", d, 0);
    repeat (200) @(negedge clk);
    chk(irq == 1'b0, "R11 no completion while disabled", irq, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule